// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

This block watches a small vector of asynchronous input pins and raises one match output when a programmable boolean product over those pins holds. The product is formed from a bank of identical bit slices. Each slice picks one synchronized pin through its field in a source-select register. It then reduces that pin to one bit according to a 3-bit condition code held in a configuration register. The condition can be a constant, a level, an edge that is remembered until software clears it, or a single-cycle edge event. The slice results are ANDed and registered onto the match output.

Software programs the block through a minimal write port. A strobe and a one-bit register select write either the source-select word or the configuration word. Any write to either word wipes the remembered edge history of every slice, which gives software a clean starting point each time it reprograms a pattern. The edge memory has two per-slice states: CLEAR, the state after reset or any write, and SEEN, entered when the selected pin shows the watched edge. The only transition back to CLEAR is a register write.

Top module: `bitslice_match`

## Requirements
- R1: While `rst_n` is low, `match_out` is 0, every condition code is 0, every source select is 0 and all edge memory is CLEAR.
- R2: Condition code 0 makes a slice contribute true at all times, so with every code at 0 `match_out` is 1 from the clock after reset release.
- R3: Codes 1, 2 and 3 make a slice true once a rising edge (1), a falling edge (2) or either edge (3) has been seen on its selected pin since the last clear, and the slice stays true until the next register write.
- R4: Any write (`wr_en` high) to either register returns the edge memory of all slices to CLEAR; an edge detected in the same cycle as the write is lost.
- R5: Code 4 makes a slice true while its selected pin is high; code 5 while it is low.
- R6: Code 6 makes a slice false at all times, forcing `match_out` to 0.
- R7: Code 7 makes a slice true for exactly one clock cycle per edge (rising or falling) on its selected pin, with no memory.
- R8: With `wr_sel`=1 the write lands in the configuration word, where slice i's code occupies `wr_data` bits [8+3i+2 : 8+3i] (slice 3 at 19:17, slice 4 at 22:20). With `wr_sel`=0 it lands in the source-select word, where slice i's pin index occupies bits [3i+2 : 3i].
- R9: Each pin passes a two-flop synchronizer and the match is registered. A pin change applied before rising edge 0 reaches `match_out` after rising edge 2 for level and event codes, and after rising edge 3 for the remembered-edge codes. A register write reaches `match_out` one edge after the write edge.
- R10: `match_out` is the AND of all slice results: it is 1 only when every slice is true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 1 selects the configuration word, 0 the source-select word |
| wr_data | input | 32 | Write data |
| pin_in | input | 8 | Raw asynchronous input pins |
| match_out | output | 1 | Registered product-term match |

## Verification
The bench builds the block with its defaults: eight slices, eight pins and the condition field starting at bit 8. These give a 32-bit configuration word in which every slice can select every pin. Two or more slices can therefore watch the same pin with conflicting conditions, which exposes the AND of contradictory terms. The full-size word also places slices 3 and 4 at their fixed bit positions. Random level patterns and random remembered-edge sequences are checked against bench functions, and directed cases pin down the edge-versus-write collision and the one-cycle event width.

// File: rtl/bsm_pkg.sv
`timescale 1ns/1ps
package bsm_pkg;
    localparam int COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        C_ONE    = 3'd0,
        C_RISE   = 3'd1,
        C_FALL   = 3'd2,
        C_EITHER = 3'd3,
        C_HIGH   = 3'd4,
        C_LOW    = 3'd5,
        C_NONE   = 3'd6,
        C_EVENT  = 3'd7
    } cond_e;
endpackage

// File: rtl/bsm_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by one history stage for edge detection.
module bsm_sync #(
    parameter int NUM_INPUTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_INPUTS-1:0] pin_in,
    output logic [NUM_INPUTS-1:0] lvl_v,
    output logic [NUM_INPUTS-1:0] rise_v,
    output logic [NUM_INPUTS-1:0] fall_v
);
    logic [NUM_INPUTS-1:0] meta_q;
    logic [NUM_INPUTS-1:0] sync_q;
    logic [NUM_INPUTS-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    always_comb begin
        lvl_v  = sync_q;
        rise_v = sync_q & ~hist_q;
        fall_v = ~sync_q & hist_q;
    end
endmodule

// File: rtl/bsm_regs.sv
`timescale 1ns/1ps
// Source-select and condition-configuration words.
module bsm_regs #(
    parameter int NUM_SLICES = 8,
    parameter int SEL_W      = 3,
    parameter int CFG_BASE   = 8,
    localparam int COND_W    = bsm_pkg::COND_W,
    localparam int SRC_W     = NUM_SLICES * SEL_W,
    localparam int CODE_W    = NUM_SLICES * COND_W,
    localparam int DATA_W    = CFG_BASE + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SRC_W-1:0]  src_q,
    output logic [CODE_W-1:0] cfg_q,
    output logic              clr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            cfg_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                cfg_q <= wr_data[DATA_W-1:CFG_BASE];
            end else begin
                src_q <= wr_data[SRC_W-1:0];
            end
        end
    end

    assign clr = wr_en;
endmodule

// File: rtl/bsm_slice.sv
`timescale 1ns/1ps
// One bit slice: pin selection, edge memory (CLEAR/SEEN) and condition decode.
module bsm_slice
    import bsm_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    parameter int SEL_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  cond_e                 code,
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_INPUTS-1:0] lvl_v,
    input  logic [NUM_INPUTS-1:0] rise_v,
    input  logic [NUM_INPUTS-1:0] fall_v,
    output logic                  res,
    output logic [1:0]            seen
);
    logic lvl;
    logic rise;
    logic fall;
    logic seen_rise_q;
    logic seen_fall_q;

    always_comb begin
        lvl  = lvl_v[sel];
        rise = rise_v[sel];
        fall = fall_v[sel];
    end

    // Edge memory: a write wins over an edge arriving in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_rise_q <= 1'b0;
            seen_fall_q <= 1'b0;
        end else if (clr) begin
            seen_rise_q <= 1'b0;
            seen_fall_q <= 1'b0;
        end else begin
            seen_rise_q <= seen_rise_q | rise;
            seen_fall_q <= seen_fall_q | fall;
        end
    end

    always_comb begin
        res = 1'b0;
        unique case (code)
            C_ONE:    res = 1'b1;
            C_RISE:   res = seen_rise_q;
            C_FALL:   res = seen_fall_q;
            C_EITHER: res = seen_rise_q | seen_fall_q;
            C_HIGH:   res = lvl;
            C_LOW:    res = ~lvl;
            C_NONE:   res = 1'b0;
            C_EVENT:  res = rise | fall;
        endcase
    end

    assign seen = {seen_fall_q, seen_rise_q};
endmodule

// File: rtl/bitslice_match.sv
`timescale 1ns/1ps
module bitslice_match
    import bsm_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    parameter int NUM_INPUTS = 8,
    parameter int CFG_BASE   = 8,
    localparam int SEL_W     = $clog2(NUM_INPUTS),
    localparam int SRC_W     = NUM_SLICES * SEL_W,
    localparam int CODE_W    = NUM_SLICES * COND_W,
    localparam int DATA_W    = CFG_BASE + CODE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [NUM_INPUTS-1:0] pin_in,
    output logic                  match_out
);
    logic [NUM_INPUTS-1:0]   lvl_v;
    logic [NUM_INPUTS-1:0]   rise_v;
    logic [NUM_INPUTS-1:0]   fall_v;
    logic [SRC_W-1:0]        src_q;
    logic [CODE_W-1:0]       cfg_q;
    logic                    clr;
    logic [NUM_SLICES-1:0]   slice_res;
    logic [2*NUM_SLICES-1:0] seen_all;
    logic                    match_q;

    bsm_sync #(.NUM_INPUTS(NUM_INPUTS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl_v  (lvl_v),
        .rise_v (rise_v),
        .fall_v (fall_v)
    );

    bsm_regs #(
        .NUM_SLICES (NUM_SLICES),
        .SEL_W      (SEL_W),
        .CFG_BASE   (CFG_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .src_q   (src_q),
        .cfg_q   (cfg_q),
        .clr     (clr)
    );

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        bsm_slice #(
            .NUM_INPUTS (NUM_INPUTS),
            .SEL_W      (SEL_W)
        ) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .code   (cond_e'(cfg_q[i*COND_W +: COND_W])),
            .sel    (src_q[i*SEL_W +: SEL_W]),
            .lvl_v  (lvl_v),
            .rise_v (rise_v),
            .fall_v (fall_v),
            .res    (slice_res[i]),
            .seen   (seen_all[2*i +: 2])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= &slice_res;
        end
    end

    assign match_out = match_q;
endmodule

// File: rtl/bitslice_match_chk.sv
`timescale 1ns/1ps
module bitslice_match_chk #(
    parameter int NUM_SLICES = 8,
    localparam int CODE_W    = NUM_SLICES * bsm_pkg::COND_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    match_out,
    input logic [2*NUM_SLICES-1:0] seen_all,
    input logic [CODE_W-1:0]       cfg_q
);
    logic any_none;

    always_comb begin
        any_none = 1'b0;
        for (int i = 0; i < NUM_SLICES; i++) begin
            if (cfg_q[i*3 +: 3] == 3'd6) any_none = 1'b1;
        end
    end

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (seen_all == '0)); // R4

    AST_SEEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((seen_all & $past(seen_all)) == $past(seen_all))); // R3

    AST_NONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        any_none |=> !match_out); // R6

    AST_ALL_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0) |=> match_out); // R2
endmodule

bind bitslice_match bitslice_match_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .match_out (match_out),
    .seen_all  (seen_all),
    .cfg_q     (cfg_q)
);

// File: tb/bitslice_match_bench.sv
`timescale 1ns/1ps
module bitslice_match_bench;
    localparam int NS = 8;
    localparam int NI = 8;
    localparam int CB = 8;
    localparam int DW = CB + 3*NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [NI-1:0] pin_in = '0;
    logic          match_out;

    int checks = 0;
    int errors = 0;
    logic [2:0] codes [NS];
    logic [2:0] sels  [NS];

    bitslice_match u_bitslice_match (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pin_in(pin_in), .match_out(match_out)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #2ms;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: match_out actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [DW-1:0] data);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [DW-1:0] pack_cfg();
        logic [DW-1:0] w = '0;
        for (int i = 0; i < NS; i++) w[CB+3*i +: 3] = codes[i];
        return w;
    endfunction

    function automatic logic [DW-1:0] pack_src();
        logic [DW-1:0] w = '0;
        for (int i = 0; i < NS; i++) w[3*i +: 3] = sels[i];
        return w;
    endfunction

    task automatic program_all();
        wr(1'b0, pack_src());
        wr(1'b1, pack_cfg());
    endtask

    task automatic clear_codes();
        for (int i = 0; i < NS; i++) begin
            codes[i] = 3'd0;
            sels[i] = 3'd0;
        end
    endtask

    function automatic logic exp_level(input logic [NI-1:0] p);
        logic r = 1'b1;
        for (int i = 0; i < NS; i++) begin
            case (codes[i])
                3'd0: r = r;
                3'd4: r = r & p[sels[i]];
                3'd5: r = r & ~p[sels[i]];
                default: r = 1'b0;
            endcase
        end
        return r;
    endfunction

    function automatic logic exp_seen(input logic [NI-1:0] ro, input logic [NI-1:0] fa);
        logic r = 1'b1;
        for (int i = 0; i < NS; i++) begin
            case (codes[i])
                3'd0: r = r;
                3'd1: r = r & ro[sels[i]];
                3'd2: r = r & fa[sels[i]];
                3'd3: r = r & (ro[sels[i]] | fa[sels[i]]);
                default: r = 1'b0;
            endcase
        end
        return r;
    endfunction

    initial begin
        logic [NI-1:0] ro;
        logic [NI-1:0] fa;
        logic [NI-1:0] prev;
        logic [NI-1:0] nxt;
        int r;
        void'($urandom(32'h5EED_0042));
        clear_codes();
        step(3);
        check("R1 reset", match_out, 1'b0);
        rst_n = 1'b1;
        check("R1 reset release", match_out, 1'b0);
        step(1);
        check("R2 all codes zero", match_out, 1'b1);

        // Slice 3 high level on pin 6 (cfg bits 19:17, src bits 11:9).
        wr(1'b0, DW'(6) << 9);
        wr(1'b1, DW'(4) << 17);
        step(2);
        check("R5 high level, pin low", match_out, 1'b0);
        pin_in[6] = 1'b1;
        step(2);
        check("R9 level latency not yet", match_out, 1'b0);
        step(1);
        check("R8 R9 slice3 field, level seen", match_out, 1'b1);
        // Slice 4 low level on the same pin (cfg bits 22:20).
        wr(1'b0, (DW'(6) << 9) | (DW'(6) << 12));
        wr(1'b1, (DW'(4) << 17) | (DW'(5) << 20));
        step(2);
        check("R10 contradictory slices", match_out, 1'b0);
        pin_in[6] = 1'b0;
        wr(1'b1, DW'(5) << 20);
        step(3);
        check("R5 low level slice4", match_out, 1'b1);

        // Code 6 disables.
        wr(1'b1, DW'(6) << (CB + 21));
        step(1);
        check("R9 write latency", match_out, 1'b0);
        step(2);
        check("R6 disabled slice", match_out, 1'b0);

        // Event on pin 2, slice 0.
        wr(1'b0, DW'(2));
        wr(1'b1, DW'(7) << CB);
        step(3);
        check("R7 no event", match_out, 1'b0);
        pin_in[2] = 1'b1;
        step(2);
        check("R7 event latency", match_out, 1'b0);
        step(1);
        check("R7 event pulse", match_out, 1'b1);
        step(1);
        check("R7 event one cycle", match_out, 1'b0);
        step(3);
        check("R7 steady high no event", match_out, 1'b0);

        // Remembered rising edge on pin 1, slice 0.
        wr(1'b0, DW'(1));
        wr(1'b1, DW'(1) << CB);
        pin_in[1] = 1'b1;
        step(1);
        pin_in[1] = 1'b0;
        step(2);
        check("R9 seen latency not yet", match_out, 1'b0);
        step(1);
        check("R3 rise seen", match_out, 1'b1);
        step(10);
        check("R3 rise held", match_out, 1'b1);
        wr(1'b0, DW'(1));
        step(1);
        check("R4 source write clears", match_out, 1'b0);
        step(5);
        check("R4 stays clear", match_out, 1'b0);

        wr(1'b1, DW'(2) << CB);
        pin_in[1] = 1'b1;
        step(6);
        check("R3 fall code ignores rise", match_out, 1'b0);
        pin_in[1] = 1'b0;
        step(4);
        check("R3 fall seen", match_out, 1'b1);
        wr(1'b1, DW'(3) << CB);
        step(2);
        check("R4 config write clears", match_out, 1'b0);
        pin_in[1] = 1'b1;
        step(4);
        check("R3 either edge seen", match_out, 1'b1);

        // Edge arriving in the write cycle is lost.
        pin_in[1] = 1'b0;
        step(5);
        wr(1'b1, DW'(1) << CB);
        step(2);
        check("R4 cleared before collision", match_out, 1'b0);
        pin_in[1] = 1'b1;
        step(2);
        wr(1'b1, DW'(1) << CB);
        step(5);
        check("R4 write wins over edge", match_out, 1'b0);
        pin_in[1] = 1'b0;
        step(5);
        pin_in[1] = 1'b1;
        step(4);
        check("R3 later edge seen", match_out, 1'b1);

        // Random level patterns.
        for (int it = 0; it < 40; it++) begin
            for (int i = 0; i < NS; i++) begin
                sels[i] = 3'($urandom % NI);
                r = int'($urandom % 8);
                codes[i] = (r < 4) ? 3'd0 : (r < 6) ? 3'd4 : (r == 6) ? 3'd5 : 3'd6;
            end
            program_all();
            pin_in = NI'($urandom);
            step(4);
            check("R5 R10 random level", match_out, exp_level(pin_in));
        end

        // Random remembered-edge sequences.
        for (int it = 0; it < 20; it++) begin
            for (int i = 0; i < NS; i++) begin
                sels[i] = 3'($urandom % NI);
                r = int'($urandom % 6);
                codes[i] = (r < 3) ? 3'd0 : 3'(r - 2);
            end
            step(4);
            program_all();
            ro = '0;
            fa = '0;
            prev = pin_in;
            for (int k = 0; k < 3; k++) begin
                nxt = NI'($urandom);
                ro = ro | (nxt & ~prev);
                fa = fa | (~nxt & prev);
                prev = nxt;
                pin_in = nxt;
                step(5);
                check("R3 R4 random edges", match_out, exp_seen(ro, fa));
            end
        end

        summary();
        $finish;
    end
endmodule